// File: doc/BRIEF.md
# Two-Level Page Table Refill Walker

This block refills a translation buffer in hardware after a lookup misses. Given the faulting virtual address, the access kind and the current address-space identifier, it finds the page directory, reads the first-level entry for the address, and then reads the even and odd page table entries of the page pair from the second-level table. Each raw entry is shifted right by six to form the low half of a translation entry. The pair is written into the buffer slot named by the replacement index sampled at start, tagged with the page-pair number and the identifier. The walker then reports what the original access would now see: a hit with its physical address, an invalid-page fault, a write to a clean page, or no mapping at all.

The walker does not take the directory location as an input. On the first walk after reset it reads two instruction words of the refill handler and rebuilds a kernel-segment pointer from their immediates. It keeps that pointer. On every walk it reads the directory base through the pointer. All table pointers are kernel-segment addresses, and the walker converts each one to a physical address by subtracting 0x80000000. Memory is reached through a 32-bit read port with a request handshake and a response pulse. Only one read is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The first-level read address is the directory base minus 0x80000000 plus virtual address bits 31:22 times 4.
- R2: The second-level reads use the word from the first level minus 0x80000000 plus virtual address bits 21:13 times 8. The even entry is read at that address and the odd entry at that address plus 4. The reads are issued in the order directory, first level, even, odd.
- R3: A completed walk makes exactly one buffer write pulse. It carries the replacement index, the identifier sampled at start, bits 31:13 of the faulting address as the page-pair number, and each raw entry shifted right by 6. The done pulse follows in the next cycle.
- R4: Address bit 12 selects the odd value (1) or the even value (0). The result code is 2'b10 (invalid) when its bit 1 is clear. It is 2'b11 (modified) on a write when its bit 2 is clear. Otherwise it is 2'b00 (hit), with the physical address equal to value bits 25:6 above the address bits 11:0.
- R5: A directory base word of zero ends the walk with code 2'b01 (no mapping). No table read and no buffer write follow.
- R6: The first walk after reset reads the handler words at the handler base and at the handler base plus 8. It forms the upper immediate shifted left by 16 plus the sign-extended lower immediate, and reads the directory base at that value minus 0x80000000. Later walks skip the handler reads.
- R7: A decoded pointer that is not strictly between 0x80000000 and 0xA0000000 is rejected. That walk and every later walk until reset end with code 2'b01 and issue no further reads.
- R8: An error response on any read ends the walk with code 2'b01 and no buffer write.
- R9: Busy stays high from the accepted start to the one-cycle done pulse. A start seen while busy is ignored.
- R10: After reset the walker is idle: busy, done, read request and buffer write are all low.
- R11: A read request, once raised, holds its address until the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| fault_va_i | input | 32 | Faulting virtual address |
| is_write_i | input | 1 | Access was a store |
| asid_i | input | ASID_W | Current address-space identifier |
| random_idx_i | input | IDX_W | Replacement slot index |
| handler_base_i | input | 32 | Physical address of the refill handler code |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Physical read address |
| mem_rsp_valid_i | input | 1 | Read response pulse |
| mem_rsp_err_i | input | 1 | Read response carries an error |
| mem_rsp_data_i | input | 32 | Read response word |
| tlb_we_o | output | 1 | Buffer write pulse |
| tlb_idx_o | output | IDX_W | Slot being written |
| tlb_vpn2_o | output | 19 | Page-pair number (address bits 31:13) |
| tlb_asid_o | output | ASID_W | Identifier tag |
| tlb_lo0_o | output | 32 | Even low-half entry |
| tlb_lo1_o | output | 32 | Odd low-half entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 hit, 01 no mapping, 10 invalid, 11 modified |
| pa_o | output | 32 | Physical address on a hit |

## Verification
The assertions check the protocol rules on every cycle: the single-cycle done pulse inside busy, a quiet port while idle, a request held stable until accepted, a buffer write always followed by a done with a mapped result, and an error response always ending in a no-mapping completion. Only the bench's scenarios can show the arithmetic. That covers the four read addresses, the shifted entry pair and its tags, the classification with the physical address, the one-time handler decode with its strict window and sign extension, and the aborts on a zero directory base and on an error response.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam logic [31:0] KSEG_LO  = 32'h8000_0000;
    localparam logic [31:0] KSEG_HI  = 32'hA000_0000;
    localparam int          LO_SHIFT = 6;
    localparam logic [31:0] ODD_STEP = 32'd4;
    localparam logic [31:0] HB_SKIP  = 32'd8;

    typedef enum logic [1:0] {
        RES_MATCH    = 2'b00,
        RES_NOMATCH  = 2'b01,
        RES_INVALID  = 2'b10,
        RES_MODIFIED = 2'b11
    } walk_res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE_HI,
        ST_PROBE_LO,
        ST_READ_ROOT,
        ST_READ_DIR,
        ST_READ_EVEN,
        ST_READ_ODD,
        ST_WRITE_TLB,
        ST_DONE
    } walk_state_e;

    function automatic logic [31:0] kseg_to_phys(input logic [31:0] p);
        return p - KSEG_LO;
    endfunction

    function automatic logic [31:0] pte_to_lo(input logic [31:0] raw);
        return raw >> LO_SHIFT;
    endfunction

endpackage

// File: rtl/ptw_locator.sv
module ptw_locator
    import pt_walker_pkg::*;
(
    input  logic [15:0] imm_hi,
    input  logic [15:0] imm_lo,
    output logic [31:0] ptr_phys,
    output logic        ptr_ok
);
    logic [31:0] ptr_virt;

    always_comb begin
        ptr_virt = {imm_hi, 16'h0000} + {{16{imm_lo[15]}}, imm_lo};
        ptr_ok   = (ptr_virt > KSEG_LO) && (ptr_virt < KSEG_HI);
        ptr_phys = kseg_to_phys(ptr_virt);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import pt_walker_pkg::*;
#(
    parameter int DIR_BITS = 10,
    parameter int PT_BITS  = 9
) (
    input  logic [DIR_BITS-1:0] dir_idx,
    input  logic [PT_BITS-1:0]  pt_idx,
    input  logic [31:0]         dir_base,
    input  logic [31:0]         pt_ptr,
    output logic [31:0]         dir_addr,
    output logic [31:0]         even_addr,
    output logic [31:0]         odd_addr
);
    localparam int DIR_PAD = 32 - DIR_BITS - 2;
    localparam int PT_PAD  = 32 - PT_BITS - 3;

    always_comb begin
        dir_addr  = kseg_to_phys(dir_base) + {{DIR_PAD{1'b0}}, dir_idx, 2'b00};
        even_addr = kseg_to_phys(pt_ptr) + {{PT_PAD{1'b0}}, pt_idx, 3'b000};
        odd_addr  = even_addr + ODD_STEP;
    end
endmodule

// File: rtl/ptw_outcome.sv
module ptw_outcome
    import pt_walker_pkg::*;
(
    input  logic        odd_sel,
    input  logic        is_write,
    input  logic [11:0] page_off,
    input  logic [19:0] pfn_even,
    input  logic        v_even,
    input  logic        d_even,
    input  logic [19:0] pfn_odd,
    input  logic        v_odd,
    input  logic        d_odd,
    output walk_res_e   res,
    output logic [31:0] pa
);
    logic [19:0] pfn;
    logic        v;
    logic        d;

    always_comb begin
        pfn = odd_sel ? pfn_odd : pfn_even;
        v   = odd_sel ? v_odd   : v_even;
        d   = odd_sel ? d_odd   : d_even;
        pa  = {pfn, page_off};
        if (!v)                 res = RES_INVALID;
        else if (is_write && !d) res = RES_MODIFIED;
        else                    res = RES_MATCH;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       fault_va_i,
    input  logic              is_write_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [IDX_W-1:0]  random_idx_i,
    input  logic [31:0]       handler_base_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [31:0]       mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic              mem_rsp_err_i,
    input  logic [31:0]       mem_rsp_data_i,
    output logic              tlb_we_o,
    output logic [IDX_W-1:0]  tlb_idx_o,
    output logic [18:0]       tlb_vpn2_o,
    output logic [ASID_W-1:0] tlb_asid_o,
    output logic [31:0]       tlb_lo0_o,
    output logic [31:0]       tlb_lo1_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic [31:0]       pa_o
);
    localparam int DIR_BITS = 10;
    localparam int PT_BITS  = 9;

    walk_state_e       state;
    logic [31:0]       va_q;
    logic              wr_q;
    logic [ASID_W-1:0] asid_q;
    logic [IDX_W-1:0]  idx_q;
    logic [15:0]       imm_hi_q;
    logic [31:0]       ptr_q;
    logic              probed_q;
    logic              found_q;
    logic [31:0]       dir_base_q;
    logic [31:0]       pt_ptr_q;
    logic [31:0]       lo0_q;
    logic [31:0]       lo1_q;
    logic              sent_q;
    walk_res_e         res_q;
    logic [31:0]       pa_q;

    logic [31:0] loc_ptr;
    logic        loc_ok;
    logic [31:0] dir_addr, even_addr, odd_addr;
    walk_res_e   out_res;
    logic [31:0] out_pa;
    logic        rd_state;
    logic        rsp_take;

    ptw_locator u_loc (
        .imm_hi   (imm_hi_q),
        .imm_lo   (mem_rsp_data_i[15:0]),
        .ptr_phys (loc_ptr),
        .ptr_ok   (loc_ok)
    );

    ptw_addr_gen #(.DIR_BITS(DIR_BITS), .PT_BITS(PT_BITS)) u_agen (
        .dir_idx   (va_q[31:32-DIR_BITS]),
        .pt_idx    (va_q[31-DIR_BITS:32-DIR_BITS-PT_BITS]),
        .dir_base  (dir_base_q),
        .pt_ptr    (pt_ptr_q),
        .dir_addr  (dir_addr),
        .even_addr (even_addr),
        .odd_addr  (odd_addr)
    );

    ptw_outcome u_out (
        .odd_sel  (va_q[12]),
        .is_write (wr_q),
        .page_off (va_q[11:0]),
        .pfn_even (lo0_q[25:6]),
        .v_even   (lo0_q[1]),
        .d_even   (lo0_q[2]),
        .pfn_odd  (lo1_q[25:6]),
        .v_odd    (lo1_q[1]),
        .d_odd    (lo1_q[2]),
        .res      (out_res),
        .pa       (out_pa)
    );

    always_comb begin
        rd_state = (state == ST_PROBE_HI) || (state == ST_PROBE_LO) ||
                   (state == ST_READ_ROOT) || (state == ST_READ_DIR) ||
                   (state == ST_READ_EVEN) || (state == ST_READ_ODD);
        rsp_take = rd_state && sent_q && mem_rsp_valid_i;
        unique case (state)
            ST_PROBE_HI:  mem_req_addr_o = handler_base_i;
            ST_PROBE_LO:  mem_req_addr_o = handler_base_i + HB_SKIP;
            ST_READ_ROOT: mem_req_addr_o = ptr_q;
            ST_READ_DIR:  mem_req_addr_o = dir_addr;
            ST_READ_EVEN: mem_req_addr_o = even_addr;
            ST_READ_ODD:  mem_req_addr_o = odd_addr;
            default:      mem_req_addr_o = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            wr_q       <= 1'b0;
            asid_q     <= '0;
            idx_q      <= '0;
            imm_hi_q   <= '0;
            ptr_q      <= '0;
            probed_q   <= 1'b0;
            found_q    <= 1'b0;
            dir_base_q <= '0;
            pt_ptr_q   <= '0;
            lo0_q      <= '0;
            lo1_q      <= '0;
            sent_q     <= 1'b0;
            res_q      <= RES_NOMATCH;
            pa_q       <= '0;
        end else begin
            if (rd_state && !sent_q && mem_req_ready_i) sent_q <= 1'b1;
            if (rsp_take) sent_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_i) begin
                    va_q   <= fault_va_i;
                    wr_q   <= is_write_i;
                    asid_q <= asid_i;
                    idx_q  <= random_idx_i;
                    pa_q   <= '0;
                    res_q  <= RES_NOMATCH;
                    if (!probed_q)     state <= ST_PROBE_HI;
                    else if (found_q)  state <= ST_READ_ROOT;
                    else               state <= ST_DONE;
                end
                ST_WRITE_TLB: begin
                    res_q <= out_res;
                    pa_q  <= out_pa;
                    state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: if (rsp_take) begin
                    if (mem_rsp_err_i) begin
                        res_q <= RES_NOMATCH;
                        state <= ST_DONE;
                    end else begin
                        unique case (state)
                            ST_PROBE_HI: begin
                                imm_hi_q <= mem_rsp_data_i[15:0];
                                state    <= ST_PROBE_LO;
                            end
                            ST_PROBE_LO: begin
                                probed_q <= 1'b1;
                                found_q  <= loc_ok;
                                ptr_q    <= loc_ptr;
                                state    <= loc_ok ? ST_READ_ROOT : ST_DONE;
                            end
                            ST_READ_ROOT: begin
                                dir_base_q <= mem_rsp_data_i;
                                state <= (mem_rsp_data_i == 32'h0) ? ST_DONE : ST_READ_DIR;
                            end
                            ST_READ_DIR: begin
                                pt_ptr_q <= mem_rsp_data_i;
                                state    <= ST_READ_EVEN;
                            end
                            ST_READ_EVEN: begin
                                lo0_q <= pte_to_lo(mem_rsp_data_i);
                                state <= ST_READ_ODD;
                            end
                            ST_READ_ODD: begin
                                lo1_q <= pte_to_lo(mem_rsp_data_i);
                                state <= ST_WRITE_TLB;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    assign mem_req_valid_o = rd_state && !sent_q;
    assign tlb_we_o   = (state == ST_WRITE_TLB);
    assign tlb_idx_o  = idx_q;
    assign tlb_vpn2_o = va_q[31:13];
    assign tlb_asid_o = asid_q;
    assign tlb_lo0_o  = lo0_q;
    assign tlb_lo1_o  = lo1_q;
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = (state == ST_DONE);
    assign result_o   = res_q;
    assign pa_o       = pa_q;
endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva (
    input logic        clk,
    input logic        rst,
    input logic        mem_req_valid_o,
    input logic        mem_req_ready_i,
    input logic [31:0] mem_req_addr_o,
    input logic        mem_rsp_valid_i,
    input logic        mem_rsp_err_i,
    input logic        tlb_we_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [1:0]  result_o
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_req_valid_o && !tlb_we_o));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    assert_write_then_done_R3: assert property (@(posedge clk) disable iff (rst)
        tlb_we_o |=> (done_o && result_o != 2'b01));

    assert_err_aborts_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mem_rsp_valid_i && mem_rsp_err_i) |=> (done_o && !tlb_we_o && result_o == 2'b01));
endmodule

bind pt_walker pt_walker_sva u_sva (
    .clk             (clk),
    .rst             (rst),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .tlb_we_o        (tlb_we_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .result_o        (result_o)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    localparam logic [31:0] HB       = 32'h0000_0100;
    localparam logic [31:0] DIR_PHYS = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] fault_va_i = '0;
    logic        is_write_i = 1'b0;
    logic [7:0]  asid_i = '0;
    logic [3:0]  random_idx_i = '0;
    logic [31:0] handler_base_i = HB;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic        mem_rsp_err_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        tlb_we_o;
    logic [3:0]  tlb_idx_o;
    logic [18:0] tlb_vpn2_o;
    logic [7:0]  tlb_asid_o;
    logic [31:0] tlb_lo0_o, tlb_lo1_o;
    logic        busy_o, done_o;
    logic [1:0]  result_o;
    logic [31:0] pa_o;

    pt_walker #(.IDX_W(4), .ASID_W(8)) uut (.*);

    always #4 clk = ~clk;

    // memory model configuration
    logic [15:0] hi_imm = 16'h8001;
    logic [15:0] lo_imm = 16'hF000;
    logic [31:0] dir_base_val = 32'h8010_0000;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    int n_chk = 0;
    int n_fail = 0;

    // logs written only by the monitor block
    logic [31:0] rd_log [0:1023];
    int          n_rd = 0;
    int          n_we = 0;
    logic [3:0]  we_idx;
    logic [18:0] we_vpn;
    logic [7:0]  we_asid;
    logic [31:0] we_lo0, we_lo1;

    function automatic logic [31:0] root_phys();
        return ({hi_imm, 16'h0} + {{16{lo_imm[15]}}, lo_imm}) - 32'h8000_0000;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a == HB)                      return {16'h3c1b, hi_imm};
        if (a == HB + 4)                  return 32'h401a_4000;
        if (a == HB + 8)                  return {16'h8f7b, lo_imm};
        if (a == root_phys())             return dir_base_val;
        if (a >= DIR_PHYS && a < DIR_PHYS + 32'h1000)
            return 32'h8020_0000 + ((a - DIR_PHYS) >> 2) * 32'h1000;
        return (a * 32'h9E37_79B1) ^ (a >> 7);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder and buffer-write monitor
    initial begin
        logic [31:0] lat_addr;
        int          stall;
        stall = 0;
        lat_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            mem_rsp_err_i   = 1'b0;
            if (rst) begin
                mem_req_ready_i = 1'b0;
                stall = 0;
            end else if (mem_req_ready_i) begin
                mem_req_ready_i = 1'b0;
                mem_rsp_valid_i = 1'b1;
                mem_rsp_err_i   = (lat_addr == err_addr);
                mem_rsp_data_i  = mem_word(lat_addr);
                rd_log[n_rd % 1024] = lat_addr;
                n_rd++;
            end else if (mem_req_valid_o) begin
                if (stall < (n_rd % 3)) stall++;
                else begin
                    stall = 0;
                    mem_req_ready_i = 1'b1;
                    lat_addr = mem_req_addr_o;
                end
            end
            if (tlb_we_o) begin
                we_idx = tlb_idx_o; we_vpn = tlb_vpn2_o; we_asid = tlb_asid_o;
                we_lo0 = tlb_lo0_o; we_lo1 = tlb_lo1_o;
                n_we++;
            end
        end
    end

    int          rd_base, we_base;
    logic [1:0]  got_res;
    logic [31:0] got_pa;
    logic        busy_ok, done_seen;

    task automatic do_walk(input logic [31:0] va, input logic wr, input logic [7:0] asid,
                           input logic [3:0] idx, input logic poke);
        int cyc;
        @(negedge clk);
        #1;
        rd_base = n_rd; we_base = n_we;
        fault_va_i = va; is_write_i = wr; asid_i = asid; random_idx_i = idx;
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0; random_idx_i = ~idx; asid_i = ~asid; fault_va_i = ~va;
        is_write_i = ~wr;
        busy_ok = 1'b1; cyc = 0;
        while (!done_o && cyc < 400) begin
            if (!busy_o) busy_ok = 1'b0;
            start_i = (poke && cyc == 2);
            @(negedge clk);
            #1;
            cyc++;
        end
        start_i = 1'b0;
        done_seen = done_o;
        got_res = result_o;
        got_pa = pa_o;
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_walk(input logic [31:0] va, input logic wr, input logic [7:0] asid,
                              input logic [3:0] idx, input logic probe);
        logic [31:0] dphys, ptphys, lo0, lo1, sel, epa;
        logic [1:0]  eres;
        int off;
        off = probe ? 2 : 0;
        dphys  = dir_base_val - 32'h8000_0000 + {20'h0, va[31:22], 2'b00};
        ptphys = mem_word(dphys) - 32'h8000_0000 + {20'h0, va[21:13], 3'b000};
        lo0 = mem_word(ptphys) >> 6;
        lo1 = mem_word(ptphys + 4) >> 6;
        sel = va[12] ? lo1 : lo0;
        epa = {sel[25:6], va[11:0]};
        if (!sel[1])            eres = 2'b10;
        else if (wr && !sel[2]) eres = 2'b11;
        else                    eres = 2'b00;
        chk("R9 done seen", {31'h0, done_seen}, 32'h1);
        chk("R9 busy held", {31'h0, busy_ok}, 32'h1);
        chk("R2 read count", n_rd - rd_base, probe ? 6 : 4);
        if (probe) begin
            chk("R6 handler word0", rd_log[rd_base % 1024], HB);
            chk("R6 handler word2", rd_log[(rd_base + 1) % 1024], HB + 8);
        end
        chk("R6 root read", rd_log[(rd_base + off) % 1024], root_phys());
        chk("R1 dir address", rd_log[(rd_base + off + 1) % 1024], dphys);
        chk("R2 even address", rd_log[(rd_base + off + 2) % 1024], ptphys);
        chk("R2 odd address", rd_log[(rd_base + off + 3) % 1024], ptphys + 4);
        chk("R3 write count", n_we - we_base, 1);
        chk("R3 index", {28'h0, we_idx}, {28'h0, idx});
        chk("R3 vpn2", {13'h0, we_vpn}, {13'h0, va[31:13]});
        chk("R3 asid", {24'h0, we_asid}, {24'h0, asid});
        chk("R3 lo0", we_lo0, lo0);
        chk("R3 lo1", we_lo1, lo1);
        chk("R4 result", {30'h0, got_res}, {30'h0, eres});
        if (eres == 2'b00) chk("R4 phys addr", got_pa, epa);
    endtask

    task automatic check_abort(input string tag, input int nreads);
        chk({tag, " done"}, {31'h0, done_seen}, 32'h1);
        chk({tag, " result"}, {30'h0, got_res}, 32'h1);
        chk({tag, " reads"}, n_rd - rd_base, nreads);
        chk({tag, " no write"}, n_we - we_base, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] va;
        reset_dut();
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", {31'h0, busy_o}, 0);
        chk("R10 done", {31'h0, done_o}, 0);
        chk("R10 req", {31'h0, mem_req_valid_o}, 0);
        chk("R10 we", {31'h0, tlb_we_o}, 0);

        // first walk decodes the handler (R6, sign-extended low immediate)
        va = 32'h0040_5123;
        do_walk(va, 1'b0, 8'h5A, 4'h3, 1'b0);
        check_walk(va, 1'b0, 8'h5A, 4'h3, 1'b1);

        // sweep of addresses, access kinds, identifiers and slots
        for (int k = 0; k < 48; k++) begin
            va = k * 32'h0A3C_5E1B + 32'h0012_3000;
            do_walk(va, k[0], 8'(k * 7), 4'(k), 1'b0);
            check_walk(va, k[0], 8'(k * 7), 4'(k), 1'b0);
        end

        // R9 start while busy is ignored
        va = 32'h1234_5678;
        do_walk(va, 1'b1, 8'h11, 4'h9, 1'b1);
        check_walk(va, 1'b1, 8'h11, 4'h9, 1'b0);
        @(negedge clk);
        chk("R9 no second walk", {31'h0, busy_o}, 0);

        // R8 error on the even entry read
        va = 32'h0080_2000;
        err_addr = dir_base_val - 32'h8000_0000 + {20'h0, va[31:22], 2'b00};
        err_addr = mem_word(err_addr) - 32'h8000_0000 + {20'h0, va[21:13], 3'b000};
        do_walk(va, 1'b0, 8'h01, 4'h2, 1'b0);
        check_abort("R8", 3);
        err_addr = 32'hFFFF_FFFF;

        // R5 zero directory base
        dir_base_val = 32'h0;
        do_walk(32'h0300_1000, 1'b0, 8'h02, 4'h4, 1'b0);
        check_abort("R5", 1);
        dir_base_val = 32'h8010_0000;

        // R7 pointer at upper bound is rejected, and stays rejected
        hi_imm = 16'hA000; lo_imm = 16'h0000;
        reset_dut();
        do_walk(32'h0040_0000, 1'b0, 8'h03, 4'h1, 1'b0);
        check_abort("R7 upper", 2);
        do_walk(32'h0040_0000, 1'b0, 8'h03, 4'h1, 1'b0);
        check_abort("R7 sticky", 0);

        // R7 pointer equal to lower bound is rejected
        hi_imm = 16'h8000; lo_imm = 16'h0000;
        reset_dut();
        do_walk(32'h0040_0000, 1'b0, 8'h03, 4'h1, 1'b0);
        check_abort("R7 lower", 2);

        // R6 positive low immediate accepted after reset
        hi_imm = 16'h8000; lo_imm = 16'h7F00;
        reset_dut();
        va = 32'h7FFF_F004;
        do_walk(va, 1'b1, 8'hC3, 4'hF, 1'b0);
        check_walk(va, 1'b1, 8'hC3, 4'hF, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule